// File: doc/BRIEF.md
# Self-Timed Write Cycle Sequencer

This block controls the internal programming phase of a serial EEPROM-style memory. The bus front end pulses `first_bit_stb` on the SCL rising edge that latches bit D0 of the first data byte of a write. Later it pulses `start_req` when the STOP condition closes a valid byte, page or protect-register write. The sequencer then raises `busy` for a programmable number of system clocks. While `busy` is high the front end refuses all bus commands. When the count runs out without trouble, the sequencer pulses `commit` so the buffered bytes are written into the array.

The write-protect pin and a low-supply indicator come in asynchronously and each passes through a parameterised synchronizer. Write-protect has no effect until the D0 strobe has armed the block. From that point until the end of the programming count, a high level on write-protect cancels the write at once. The block goes back to idle without waiting out the rest of the count, issues no commit pulse, and sets a sticky `aborted` flag that marks the target data as unreliable. A low supply cancels a write in the same way. It therefore prevents a write from both starting and completing.

Top module: `wr_cycle_seq`

## Requirements
- R1: While reset is asserted, and on the first clock after its release, `busy`, `commit` and `aborted` are all low.
- R2: `start_req` is accepted only when a `first_bit_stb` pulse has armed the block since it last returned to idle. An unarmed request leaves `busy` low.
- R3: An accepted `start_req` raises `busy` on the next clock edge. `busy` then stays high for exactly CYCLE_CLKS clock cycles unless the write is cancelled.
- R4: A write that completes raises `commit` for exactly one cycle, the first cycle in which `busy` is low again. `aborted` stays low.
- R5: While the block is idle, `wp_pin` has no effect. Toggling it before the D0 strobe neither sets `aborted` nor prevents the following write.
- R6: `wp_pin` and `low_supply` each pass through SYNC_STAGES flip-flops. If `wp_pin` is high while the block is armed or busy, the write is cancelled: `busy` is low SYNC_STAGES+1 edges after the first edge that samples the pin high, no `commit` follows, and `aborted` becomes 1. A cancelled armed write needs a new D0 strobe before any request is accepted.
- R7: `aborted` stays set until the next accepted write. It clears on the same edge on which `busy` rises, so `busy` and `aborted` are never high together.
- R8: If `low_supply` is high while the block is armed or busy, the write is cancelled exactly as in R6: no start, no commit, and `aborted` is set.
- R9: `first_bit_stb` and `start_req` pulses that arrive while `busy` is high are ignored. They neither lengthen nor restart the count, and they do not arm a later write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle pulse: STOP closed a valid write |
| first_bit_stb | input | 1 | One-cycle pulse: SCL edge that captured D0 of the first data byte |
| wp_pin | input | 1 | Write-protect pin, asynchronous, high cancels |
| low_supply | input | 1 | Supply below threshold, asynchronous |
| busy | output | 1 | Programming cycle in progress; bus commands refused |
| commit | output | 1 | One-cycle pulse: write buffered bytes into the array |
| aborted | output | 1 | Sticky: last write was cancelled, data unreliable |

## Verification
A sequencer stuck in the armed state would accept a later stray request, which shows up as an unexpected rise of `busy` on the edge after that request. A counter that is off by one moves the fall of `busy` and the `commit` pulse by a cycle, and the per-clock comparison against the reference model catches this in that very cycle. If the guard path skipped or added a synchronizer stage, the cancellation latency would move away from SYNC_STAGES+1 edges, and the bench measures that latency directly. A sticky flag that cleared early or late disagrees with the model on the first idle cycle or on the rise of `busy`.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
   typedef enum logic [1:0] {
      WCS_IDLE  = 2'd0,
      WCS_ARMED = 2'd1,
      WCS_PROG  = 2'd2
   } wcs_state_e;

   localparam int unsigned WCS_MAX_SYNC = 4;
endpackage

// File: rtl/wcs_sync.sv
module wcs_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/wcs_timer.sv
module wcs_timer #(
   parameter int unsigned CYCLE_CLKS = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic last
);
   localparam int unsigned CW = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;

   generate
      if (CYCLE_CLKS == 1) begin : g_single
         assign last = run;
      end else begin : g_count
         localparam logic [CW-1:0] LAST_VAL = CW'(CYCLE_CLKS - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      cnt_q <= '0;
            else if (clear)                  cnt_q <= '0;
            else if (run && cnt_q != LAST_VAL) cnt_q <= cnt_q + 1'b1;
         end
         assign last = run && (cnt_q == LAST_VAL);
      end
   endgenerate
endmodule

// File: rtl/wr_cycle_seq.sv
module wr_cycle_seq
   import wcs_pkg::*;
#(
   parameter int unsigned CYCLE_CLKS  = 1000000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic first_bit_stb,
   input  logic wp_pin,
   input  logic low_supply,
   output logic busy,
   output logic commit,
   output logic aborted
);
   generate
      if (CYCLE_CLKS < 1) begin : g_bad_cycle
         $error("wr_cycle_seq: CYCLE_CLKS must be at least 1");
      end
      if (SYNC_STAGES > WCS_MAX_SYNC) begin : g_bad_sync
         $error("wr_cycle_seq: SYNC_STAGES exceeds supported depth");
      end
   endgenerate

   logic       wp_s, lv_s, guard;
   logic       enter_prog, finish, cancel, cycle_last;
   wcs_state_e state_q, state_d;
   logic       commit_q, aborted_q;

   wcs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   ({wp_pin, low_supply}),
      .q   ({wp_s, lv_s})
   );

   assign guard = wp_s | lv_s;

   always_comb begin
      state_d    = state_q;
      enter_prog = 1'b0;
      finish     = 1'b0;
      cancel     = 1'b0;
      unique case (state_q)
         WCS_IDLE: begin
            if (first_bit_stb) state_d = WCS_ARMED;
         end
         WCS_ARMED: begin
            if (guard) begin
               state_d = WCS_IDLE;
               cancel  = 1'b1;
            end else if (start_req) begin
               state_d    = WCS_PROG;
               enter_prog = 1'b1;
            end
         end
         WCS_PROG: begin
            if (guard) begin
               state_d = WCS_IDLE;
               cancel  = 1'b1;
            end else if (cycle_last) begin
               state_d = WCS_IDLE;
               finish  = 1'b1;
            end
         end
         default: state_d = WCS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= WCS_IDLE;
         commit_q  <= 1'b0;
         aborted_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         commit_q <= finish;
         if (cancel)          aborted_q <= 1'b1;
         else if (enter_prog) aborted_q <= 1'b0;
      end
   end

   wcs_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (enter_prog),
      .run   (busy),
      .last  (cycle_last)
   );

   assign busy    = (state_q == WCS_PROG);
   assign commit  = commit_q;
   assign aborted = aborted_q;
endmodule

// File: rtl/wcs_checker.sv
module wcs_checker #(
   parameter int unsigned CYCLE_CLKS  = 1000000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic start_req,
   input logic first_bit_stb,
   input logic wp_pin,
   input logic low_supply,
   input logic busy,
   input logic commit,
   input logic aborted
);
   int unsigned run_len;
   int unsigned guard_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len   <= 0;
         guard_run <= 0;
      end else begin
         run_len   <= busy ? run_len + 1 : 0;
         guard_run <= (wp_pin || low_supply) ? guard_run + 1 : 0;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (!busy && !commit && !aborted);
      end
   end

   p_busy_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_req));

   p_full_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (run_len == CYCLE_CLKS));

   p_commit_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (!busy && $past(busy)));

   p_commit_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);

   p_guard_blocks_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_run >= SYNC_STAGES + 1) |-> !busy);

   p_no_commit_when_aborted_r6: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !aborted);

   p_flag_clear_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !aborted);

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(aborted) |-> busy);
endmodule

bind wr_cycle_seq wcs_checker #(.CYCLE_CLKS(CYCLE_CLKS), .SYNC_STAGES(SYNC_STAGES)) u_wcs_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_req     (start_req),
   .first_bit_stb (first_bit_stb),
   .wp_pin        (wp_pin),
   .low_supply    (low_supply),
   .busy          (busy),
   .commit        (commit),
   .aborted       (aborted)
);

// File: tb/test_wr_cycle_seq.sv
`timescale 1ns/1ps
module test_wr_cycle_seq;
   localparam int N = 12;
   localparam int S = 2;

   logic clk = 1'b0;
   logic rst_n;
   logic start_req = 1'b0, first_bit_stb = 1'b0, wp_pin = 1'b0, low_supply = 1'b0;
   logic busy, commit, aborted;

   int n_checks = 0, n_err = 0;
   string phase = "R1";

   // port-level activity counters
   int run_cur = 0, run_last = 0, commit_total = 0, busy_rises = 0;
   logic busy_prev = 1'b0;

   // behavioural reference model
   bit m_armed, m_busy, m_commit, m_aborted;
   int m_cnt;
   bit wq[$];
   bit lq[$];

   always #2.5 clk = ~clk;

   wr_cycle_seq #(.CYCLE_CLKS(N), .SYNC_STAGES(S)) i_wr_cycle_seq (
      .clk (clk), .rst_n (rst_n), .start_req (start_req),
      .first_bit_stb (first_bit_stb), .wp_pin (wp_pin), .low_supply (low_supply),
      .busy (busy), .commit (commit), .aborted (aborted)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic void model_reset();
      m_armed = 0; m_busy = 0; m_commit = 0; m_aborted = 0; m_cnt = 0;
      wq.delete(); lq.delete();
      for (int i = 0; i < S; i++) begin wq.push_back(1'b0); lq.push_back(1'b0); end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         bit ws, ls, g, nc;
         if (S == 0) begin ws = wp_pin; ls = low_supply; end
         else begin
            ws = wq.pop_front(); ls = lq.pop_front();
            wq.push_back(wp_pin); lq.push_back(low_supply);
         end
         g  = ws | ls;
         nc = 0;
         if (m_busy) begin
            if (g) begin m_busy = 0; m_aborted = 1; end
            else if (m_cnt == N - 1) begin m_busy = 0; nc = 1; end
            else m_cnt++;
         end else if (m_armed) begin
            if (g) begin m_armed = 0; m_aborted = 1; end
            else if (start_req) begin m_armed = 0; m_busy = 1; m_cnt = 0; m_aborted = 0; end
         end else if (first_bit_stb) begin
            m_armed = 1;
         end
         m_commit = nc;
      end
   end

   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         check(phase, "busy vs model", busy, m_busy);
         check(phase, "commit vs model", commit, m_commit);
         check(phase, "aborted vs model", aborted, m_aborted);
         if (busy) run_cur++;
         else if (run_cur > 0) begin run_last = run_cur; run_cur = 0; end
         if (commit) commit_total++;
         if (busy && !busy_prev) busy_rises++;
         busy_prev = busy;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic pulse_d0();
      @(negedge clk) first_bit_stb = 1'b1;
      @(negedge clk) first_bit_stb = 1'b0;
   endtask
   task automatic pulse_start();
      @(negedge clk) start_req = 1'b1;
      @(negedge clk) start_req = 1'b0;
   endtask

   initial begin
      #1000000;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      int c0, r0, lat;
      rst_n = 1'b0;
      model_reset();
      idle(3);
      check("R1", "busy in reset", busy, 0);
      check("R1", "commit in reset", commit, 0);
      check("R1", "aborted in reset", aborted, 0);
      @(negedge clk) rst_n = 1'b1;
      idle(1);
      check("R1", "busy after reset", busy, 0);
      check("R1", "aborted after reset", aborted, 0);

      // R2: request without D0 strobe
      phase = "R2";
      r0 = busy_rises;
      pulse_start(); idle(N + 4);
      check("R2", "unarmed request rises", busy_rises - r0, 0);

      // R3/R4: normal write
      phase = "R3";
      c0 = commit_total;
      pulse_d0(); idle(3); pulse_start();
      check("R3", "busy right after request", busy, 1);
      idle(N + 4);
      check("R3", "busy length", run_last, N);
      check("R4", "commit pulses", commit_total - c0, 1);
      check("R4", "aborted after good write", aborted, 0);

      // R5: wp ignored while idle
      phase = "R5";
      wp_pin = 1'b1; idle(6); wp_pin = 1'b0; idle(S + 2);
      check("R5", "aborted after idle wp", aborted, 0);
      c0 = commit_total;
      pulse_d0(); idle(2); pulse_start(); idle(N + 4);
      check("R5", "write after idle wp commits", commit_total - c0, 1);

      // R6: wp while armed
      phase = "R6";
      r0 = busy_rises;
      pulse_d0(); wp_pin = 1'b1; idle(S + 3);
      check("R6", "aborted while armed", aborted, 1);
      wp_pin = 1'b0; idle(S + 2);
      pulse_start(); idle(N + 2);
      check("R6", "request after armed abort", busy_rises - r0, 0);

      // R6/R7: wp mid-cycle, latency and stickiness
      c0 = commit_total;
      pulse_d0(); idle(1); pulse_start(); idle(3);
      check("R7", "aborted cleared at accepted write", aborted, 0);
      wp_pin = 1'b1;
      lat = 0;
      while (busy && lat < 20) begin @(negedge clk); lat++; end
      check("R6", "cancel latency edges", lat, S + 1);
      idle(3);
      wp_pin = 1'b0;
      check("R6", "commit after cancel", commit_total - c0, 0);
      check("R6", "aborted after cancel", aborted, 1);
      phase = "R7";
      idle(S + 4); pulse_start(); idle(4);
      check("R7", "aborted holds through idle", aborted, 1);
      pulse_d0(); idle(1); pulse_start();
      check("R7", "busy at accepted write", busy, 1);
      check("R7", "aborted clears with busy", aborted, 0);
      idle(N + 4);
      check("R7", "run after recovery", run_last, N);

      // R8: low supply
      phase = "R8";
      r0 = busy_rises;
      pulse_d0(); low_supply = 1'b1; idle(S + 3); pulse_start(); idle(N);
      check("R8", "start under low supply", busy_rises - r0, 0);
      check("R8", "aborted under low supply", aborted, 1);
      low_supply = 1'b0; idle(S + 2);
      c0 = commit_total;
      pulse_d0(); pulse_start(); idle(2);
      low_supply = 1'b1; idle(N + 4);
      check("R8", "commit after low supply mid-cycle", commit_total - c0, 0);
      check("R8", "busy after low supply", busy, 0);
      low_supply = 1'b0; idle(S + 2);

      // R9: stray strobes during busy
      phase = "R9";
      c0 = commit_total;
      pulse_d0(); pulse_start(); idle(2);
      pulse_d0(); idle(1); pulse_start(); idle(N + 4);
      check("R9", "length with stray pulses", run_last, N);
      check("R9", "commits with stray pulses", commit_total - c0, 1);
      r0 = busy_rises;
      pulse_start(); idle(N);
      check("R9", "stray strobe did not arm", busy_rises - r0, 0);

      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule